// File: doc/BRIEF.md
# Memory Access Time Characterizer

This block is a built-in self-test sequencer for a synchronous memory whose read data takes some number of clock cycles to settle after the address changes. It writes all-zero words into the lower half of the address space and all-one words into the upper half. It then reads every word back in ascending order at a generous, safe wait, to confirm that the array holds the pattern. Only after that does it apply the timing stress.

During the stress pass, consecutive reads jump between the two halves. Every read therefore has to overturn the previous data on every bit. The wait between driving an address and sampling the read data is a whole number of clock cycles.

In characterization mode, the wait starts at a programmable maximum and drops by one cycle after each clean stress pass. The run stops at the first failing read, or after a clean pass at zero wait. The smallest wait that passed is then reported. In production mode, a single stress pass runs at a given wait, and the block reports pass or fail.

Top module: `acc_time_char`

## Requirements
- R1: After a synchronous active-low reset, busy, done, pass, init_err and mem_we are 0 and best_wait is 0.
- R2: A run begins with a fill phase of DEPTH consecutive write cycles, one for each address in ascending order from 0. Write data is all zeros when the address MSB is 0 and all ones when it is 1.
- R3: After the fill, every address is read back in ascending order using the wait given on wait_max. The expected word is again all ones exactly when the address MSB is 1. A mismatch ends the run at once with init_err=1, pass=0 and best_wait=0.
- R4: Each read holds its address and keeps mem_we low for w+1 cycles, where w is the current wait. mem_rdata is sampled in the last of those cycles. A memory whose data is valid L cycles after the address changes therefore passes exactly when w >= L. A clean production run keeps busy high for DEPTH + DEPTH*(wait_max+1) + DEPTH*(prod_wait+1) cycles.
- R5: A stress pass reads the addresses in the order 0, DEPTH/2, 1, DEPTH/2+1, … up to DEPTH/2-1, DEPTH-1.
- R6: In characterization mode (prod_mode=0), the first stress pass uses wait_max. Each clean pass lowers the wait by one. The run ends at the first failing read, or after a clean pass at wait 0. It then reports pass=1 and best_wait equal to the smallest wait that passed.
- R7: In production mode (prod_mode=1), exactly one stress pass runs at prod_wait. The result is pass=1 with best_wait=prod_wait if every read matches, and pass=0 with best_wait=0 otherwise.
- R8: start is ignored while busy. The results and done stay unchanged until the next start after completion.
- R9: busy is high from the cycle after an accepted start until the run completes. done is high from completion until the next start. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when not busy) |
| prod_mode | input | 1 | 1 selects production, 0 selects characterization |
| wait_max | input | WW | Read-back wait and starting stress wait |
| prod_wait | input | WW | Stress wait in production mode |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | Stress result |
| init_err | output | 1 | Sequential read-back failed |
| best_wait | output | WW | Smallest passing wait (or prod_wait) |

## Verification
The bench memory model returns the previous address's word until the programmed latency has elapsed. An error in the wait counter or the sampling point therefore shows up at the end of the run as a best_wait that is off by one or more from that latency. An address generator that skips or repeats an index shows up within one read, in the logged address order or the fill sequence. The busy-cycle count exposes any extra or missing cycle in a phase as soon as done rises. A wrong decrement or a wrong stop condition in the wait register shows up in best_wait, or in a pass flag that disagrees with the latency.

// File: rtl/ats_pkg.sv
// Package: shared state encoding for the access time characterizer.
// Assumes: nothing beyond standard SystemVerilog.
package ats_pkg;

    // Sequencer phases, in the order a run visits them.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_CHECK  = 3'd2,
        ST_STRESS = 3'd3,
        ST_DONE   = 3'd4
    } ats_state_e;

endpackage

// File: rtl/ats_addr_seq.sv
// Address sequencer: one index counter that is presented either as a plain
// ascending address or as an alternating lower/upper half address.
// Assumes: AW >= 2, depth is a power of two, so the index wraps to 0 on
// its own after the last address.
module ats_addr_seq #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          alt,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] idx;

    // Index register: cleared on request, advanced by one per step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    // Address view: in alternating order, bit 0 picks the half and the
    // upper index bits pick the offset inside the half.
    always_comb begin
        if (alt) begin
            addr = {idx[0], idx[AW-1:1]};
        end else begin
            addr = idx;
        end
        last = &idx;
    end

    // R2/R3: an ascending step moves to the next address.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !alt && !last) |=> (alt || addr == $past(addr) + 1'b1));

    // R5: an alternating step always crosses to the other half.
    p_alt_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && alt && !last) |=> (!alt || addr[AW-1] != $past(addr[AW-1])));

endmodule

// File: rtl/ats_wait_timer.sv
// Wait timer: counts the cycles an address has been held and flags the
// cycle in which the read data is to be sampled.
// Assumes: limit only changes together with a clear or a hit.
module ats_wait_timer #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [WW-1:0] limit,
    output logic          hit
);
    logic [WW-1:0] cnt;

    // Sample flag: the held address has been present for limit cycles.
    assign hit = en && (cnt == limit);

    // Cycle counter: restarts after every sample, counts while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || hit) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the counter never runs past the programmed wait.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= limit));

endmodule

// File: rtl/acc_time_char.sv
// Access time characterizer top: fills a memory with a half/half pattern,
// reads it back sequentially at a safe wait, then stresses it with
// alternating-half reads, either stepping the wait down (characterization)
// or at one fixed wait (production).
// Assumes: memory read data is a function of the held address after some
// number of cycles; writes take effect in the cycle they are issued.
module acc_time_char #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          prod_mode,
    input  logic [WW-1:0] wait_max,
    input  logic [WW-1:0] prod_wait,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          init_err,
    output logic [WW-1:0] best_wait
);
    import ats_pkg::*;

    ats_state_e    state;
    logic          mode_q;
    logic [WW-1:0] max_q;
    logic [WW-1:0] prod_q;
    logic [WW-1:0] cur_w;
    logic          pass_q;
    logic          err_q;
    logic [WW-1:0] best_q;

    logic          idle_like;
    logic          reading;
    logic          accept;
    logic          a_step;
    logic          a_last;
    logic          t_hit;
    logic [WW-1:0] t_limit;
    logic [DW-1:0] expect_w;
    logic          good;

    // Phase decode and handshake.
    always_comb begin
        idle_like = (state == ST_IDLE) || (state == ST_DONE);
        reading   = (state == ST_CHECK) || (state == ST_STRESS);
        accept    = idle_like && start;
    end

    // Expected word: all ones in the upper half, all zeros in the lower.
    always_comb begin
        expect_w = {DW{mem_addr[AW-1]}};
        good     = (mem_rdata == expect_w);
        t_limit  = (state == ST_CHECK) ? max_q : cur_w;
        a_step   = (state == ST_FILL) || (reading && t_hit && good);
    end

    ats_addr_seq #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .step  (a_step),
        .alt   (state == ST_STRESS),
        .addr  (mem_addr),
        .last  (a_last)
    );

    ats_wait_timer #(.WW(WW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!reading),
        .en    (reading),
        .limit (t_limit),
        .hit   (t_hit)
    );

    // Memory drive: writes only in the fill phase, pattern from address MSB.
    always_comb begin
        mem_we    = (state == ST_FILL);
        mem_wdata = expect_w;
    end

    // Sequencer: phase transitions, wait stepping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= 1'b0;
            max_q  <= '0;
            prod_q <= '0;
            cur_w  <= '0;
            pass_q <= 1'b0;
            err_q  <= 1'b0;
            best_q <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        mode_q <= prod_mode;
                        max_q  <= wait_max;
                        prod_q <= prod_wait;
                        pass_q <= 1'b0;
                        err_q  <= 1'b0;
                        best_q <= '0;
                        state  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (a_last) begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (t_hit) begin
                        if (!good) begin
                            err_q <= 1'b1;
                            state <= ST_DONE;
                        end else if (a_last) begin
                            cur_w <= mode_q ? prod_q : max_q;
                            state <= ST_STRESS;
                        end
                    end
                end
                ST_STRESS: begin
                    if (t_hit) begin
                        if (!good) begin
                            state <= ST_DONE;
                        end else if (a_last) begin
                            best_q <= cur_w;
                            pass_q <= 1'b1;
                            if (mode_q || cur_w == '0) begin
                                state <= ST_DONE;
                            end else begin
                                cur_w <= cur_w - 1'b1;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result outputs.
    always_comb begin
        busy      = !idle_like;
        done      = (state == ST_DONE);
        pass      = pass_q;
        init_err  = err_q;
        best_wait = best_q;
    end

    // R4: the address is held until its sample cycle.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && !t_hit) |=> $stable(mem_addr));

    // R6: after a clean characterization pass the wait drops by exactly one.
    p_wait_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRESS && t_hit && good && a_last && !mode_q && cur_w != '0)
        |=> (cur_w == $past(cur_w) - 1'b1));

    // R3: a read-back failure never reports a pass.
    p_err_nopass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |-> !pass);

    // R7: a passing production run reports the production wait.
    p_prod_best_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q && pass) |-> (best_wait == prod_q));

    // R8: a start while busy leaves the captured settings alone.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(max_q) && $stable(mode_q) && $stable(prod_q)));

    // R9: busy and done are exclusive.
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

// File: tb/acc_time_char_test.sv
module acc_time_char_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int HALF = DEPTH / 2;

    typedef struct {
        bit err;
        bit pass;
        int best;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          prod_mode = 1'b0;
    logic [WW-1:0] wait_max = '0;
    logic [WW-1:0] prod_wait = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, pass, init_err;
    logic [WW-1:0] best_wait;

    int n_chk = 0;
    int n_fail = 0;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    acc_time_char #(.AW(AW), .DW(DW), .WW(WW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .prod_mode(prod_mode),
        .wait_max(wait_max), .prod_wait(prod_wait),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass),
        .init_err(init_err), .best_wait(best_wait)
    );

    // Memory model: data settles lat cycles after an address change; until
    // then the previous address's word is returned.
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] cur_a = '0;
    logic [AW-1:0] prv_a = '0;
    int age = 0;
    int lat = 0;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_addr != cur_a) begin
            prv_a <= cur_a;
            cur_a <= mem_addr;
            age   <= 1;
        end else if (age < 1000) begin
            age <= age + 1;
        end
    end

    always @* begin
        if (mem_addr != cur_a) mem_rdata = (lat == 0) ? mem[mem_addr] : mem[cur_a];
        else                   mem_rdata = (age >= lat) ? mem[cur_a] : mem[prv_a];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Monitor: port activity logs and scoreboard compare on completion.
    int busy_cnt = 0;
    int fill_n = 0;
    int fill_bad = 0;
    int rd_log [$];
    logic [AW-1:0] last_seen = '0;
    logic done_d = 1'b0;

    always @(negedge clk) begin
        if (busy) busy_cnt <= busy_cnt + 1;
        if (mem_we) begin
            if (int'(mem_addr) != fill_n || mem_wdata != {DW{mem_addr[AW-1]}}) fill_bad <= fill_bad + 1;
            fill_n <= fill_n + 1;
        end
        if (busy && !mem_we && mem_addr != last_seen) rd_log.push_back(int'(mem_addr));
        last_seen <= mem_addr;
        done_d <= done;
        if (done && !done_d) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(init_err == e.err, "R3 init_err", int'(init_err), int'(e.err));
                check(pass == e.pass, "R6/R7 pass", int'(pass), int'(e.pass));
                check(int'(best_wait) == e.best, "R6/R7 best_wait", int'(best_wait), e.best);
            end
        end
    end

    // Driver: computes the expected result from the requirements, pushes it
    // to the scoreboard and runs the sequencer.
    task automatic run(input bit pm, input int wm, input int wp, input int l, input bit poke);
        exp_t e;
        bit clean;
        if (l > wm) begin
            e.err = 1'b1; e.pass = 1'b0; e.best = 0;
        end else if (pm) begin
            e.err = 1'b0; e.pass = (wp >= l); e.best = (wp >= l) ? wp : 0;
        end else begin
            e.err = 1'b0; e.pass = 1'b1; e.best = l;
        end
        sb_q.push_back(e);
        @(negedge clk);
        lat = l;
        prod_mode = pm;
        wait_max = WW'(wm);
        prod_wait = WW'(wp);
        start = 1'b1;
        busy_cnt = 0;
        fill_n = 0;
        fill_bad = 0;
        rd_log.delete();
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R9 busy after start", int'(busy), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            prod_mode = ~pm;
            wait_max = '0;
            prod_wait = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        // R2: fill covered every address once, in order, with the pattern.
        check(fill_n == DEPTH && fill_bad == 0, "R2 fill sequence", fill_n * 100 + fill_bad, DEPTH * 100);
        clean = (l <= wm);
        if (clean && pm && wp >= l) begin
            check(busy_cnt == DEPTH + DEPTH * (wm + 1) + DEPTH * (wp + 1), "R4 run length",
                  busy_cnt, DEPTH + DEPTH * (wm + 1) + DEPTH * (wp + 1));
            check(rd_log.size() == 2 * DEPTH, "R5 read count", rd_log.size(), 2 * DEPTH);
            for (int k = 0; k < DEPTH && rd_log.size() == 2 * DEPTH; k++) begin
                int ea;
                ea = (k % 2) * HALF + k / 2;
                if (rd_log[DEPTH + k] != ea) check(1'b0, "R5 stress order", rd_log[DEPTH + k], ea);
                if (rd_log[k] != k) check(1'b0, "R3 read-back order", rd_log[k], k);
            end
            check(1'b1, "R5 order scanned", 0, 0);
        end
        repeat (5) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R8 done held", int'(done), 1);
        check(int'(best_wait) == e.best && pass == e.pass, "R8 results held", int'(best_wait), e.best);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(pass == 1'b0 && init_err == 1'b0, "R1 flags", int'(pass) + int'(init_err), 0);
        check(mem_we == 1'b0 && best_wait == '0, "R1 we/best", int'(mem_we), 0);

        run(1'b0, 6, 0, 3, 1'b0);  // R6 interior latency
        run(1'b0, 5, 0, 0, 1'b0);  // R6 reaches zero wait
        run(1'b0, 6, 0, 6, 1'b0);  // R6 latency equal to maximum
        run(1'b0, 6, 0, 9, 1'b0);  // R3 read-back fails
        run(1'b1, 6, 4, 3, 1'b0);  // R7 production pass, R4/R5 timing and order
        run(1'b1, 6, 2, 3, 1'b0);  // R7 production fail
        run(1'b1, 3, 0, 0, 1'b0);  // R7 zero wait pass
        run(1'b0, 4, 0, 2, 1'b1);  // R8 start ignored while busy
        run(1'b1, 5, 5, 5, 1'b0);  // R7 boundary wait equals latency

        check(sb_q.size() == 0, "R9 every run completed", sb_q.size(), 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule